// File: doc/BRIEF.md
# Infrared Pulse Encoder and Decoder

This block sits between the bit-level transmit and receive lines of a UART and an infrared transceiver. On the way out it turns every low data bit into a single short high pulse placed in the middle of the bit period. A high data bit sends nothing. The pulse width is a 6-bit value, counted either in system clock cycles or in ticks of an internal sixteen-times-per-bit clock.

On the way in, the decoder works in three steps:
- It normalises the transceiver output to "light seen = active".
- An optional glitch filter with a 6-bit length rejects pulses that are too short.
- Each accepted pulse becomes a low level on the UART receive line, lasting until one bit period after the pulse's leading edge.

A single enable bypasses both paths. All configuration is captured only while a soft-reset input is held. The bit period is the parameter `BIT_CYC`, in clock cycles. The internal sixteen-times clock ticks every `BIT_CYC/16` cycles.

Top module: `irda_codec`

## Requirements
- R1: With the latched enable low and soft reset released, `ir_tx` equals `uart_txd` and `uart_rxd` equals `ir_rx` in the same cycle.
- R2: Take a transmit bit of value 0 held for one bit period, with base-clock counting. Let L be the pulse length value, W = L+1 and S = BIT_CYC/2 − floor(W/2). `ir_tx` is high for exactly W cycles, at phases S to S+W−1 of the bit, where phase 0 is the first cycle after the bit starts. A bit of value 1 produces no pulse.
- R3: The width counts sixteen-times ticks, so W = (L+1)·BIT_CYC/16, only when both `cfg_os16` and `cfg_tx_clk16` are 1. In every other combination it counts base cycles.
- R4: When the centred window would start before phase 0, it starts at phase 0, and the pulse never extends beyond its bit period. With BIT_CYC = 32 and L = 63, `ir_tx` is high for all 32 cycles.
- R5: With `cfg_rx_inv` = 0, a high level on `ir_rx` means light. With `cfg_rx_inv` = 1, a low level means light.
- R6: With the filter on and length F, the threshold T is 2·F, or 1 when F = 0. A light pulse lasting fewer than T cycles leaves `uart_rxd` high.
- R7: With the filter off, the threshold is T = 1, so a one-cycle light pulse is decoded.
- R8: An accepted pulse makes `uart_rxd` low for BIT_CYC − T + 1 cycles. The low ends BIT_CYC cycles after the first registered light sample.
- R9: Configuration inputs changed while `sw_rst` is low have no effect on either output.
- R10: While `sw_rst` is high, `ir_tx` is 0 and `uart_rxd` is 1, and the bit-phase, filter and decode counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the base pulse-counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Soft reset; configuration is latched while high |
| cfg_en | input | 1 | Encoder/decoder enable (0 = pass-through) |
| cfg_os16 | input | 1 | Oversampling mode on |
| cfg_tx_clk16 | input | 1 | Count pulse width on the sixteen-times clock |
| cfg_tx_len | input | 6 | Transmit pulse length value L |
| cfg_rx_inv | input | 1 | Receive polarity: 1 = light is a low level |
| cfg_rx_filt | input | 1 | Receive glitch filter enable |
| cfg_rx_len | input | 6 | Filter length value F |
| uart_txd | input | 1 | Bit stream from the UART transmitter |
| ir_tx | output | 1 | Drive to the infrared emitter |
| ir_rx | input | 1 | Output of the infrared receiver |
| uart_rxd | output | 1 | Decoded bit stream to the UART receiver |

## Verification
The bench builds the block with the default BIT_CYC of 32, so a sixteen-times tick lasts two cycles. This makes the base and oversampled pulse widths differ by a factor that is easy to count. It also lets the largest length value (63) exceed a bit period in both clock modes, so the clipping corner is reached. The filter thresholds used (1, 4 and 6 cycles) all sit well inside the 32-cycle bit. The expected decode length BIT_CYC − T + 1 can therefore be measured exactly, both just below and exactly at the threshold.

// File: rtl/irda_codec.sv
module irda_codec #(
  parameter int BIT_CYC = 32,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             cfg_en,
  input  logic             cfg_os16,
  input  logic             cfg_tx_clk16,
  input  logic [LEN_W-1:0] cfg_tx_len,
  input  logic             cfg_rx_inv,
  input  logic             cfg_rx_filt,
  input  logic [LEN_W-1:0] cfg_rx_len,
  input  logic             uart_txd,
  output logic             ir_tx,
  input  logic             ir_rx,
  output logic             uart_rxd
);
  localparam int PH_W = $clog2(BIT_CYC);
  localparam int TM_W = $clog2(BIT_CYC + 1);
  localparam int HC_W = LEN_W + 1;
  localparam logic [31:0] OS_DIV = 32'(BIT_CYC / 16);
  localparam logic [31:0] HALF   = 32'(BIT_CYC / 2);
  localparam logic [HC_W-1:0] HC_MAX = '1;

  logic             en_q, os16_q, clk16_q, inv_q, filt_q;
  logic [LEN_W-1:0] tx_len_q, rx_len_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; os16_q <= 1'b0; clk16_q <= 1'b0; inv_q <= 1'b0; filt_q <= 1'b0;
      tx_len_q <= '0; rx_len_q <= '0;
    end else if (sw_rst) begin
      en_q <= cfg_en; os16_q <= cfg_os16; clk16_q <= cfg_tx_clk16;
      inv_q <= cfg_rx_inv; filt_q <= cfg_rx_filt;
      tx_len_q <= cfg_tx_len; rx_len_q <= cfg_rx_len;
    end

  // transmit: bit phase restarts on every edge of the UART line
  logic            txd_q;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txd_q <= 1'b1; phase <= '0;
    end else if (sw_rst) begin
      txd_q <= 1'b1; phase <= '0;
    end else if (uart_txd != txd_q) begin
      txd_q <= uart_txd; phase <= '0;
    end else begin
      phase <= (phase == PH_W'(BIT_CYC - 1)) ? '0 : phase + 1'b1;
    end

  logic [31:0] tx_w, tx_start, tx_end;
  logic        tx_pulse;

  assign tx_w     = (32'(tx_len_q) + 32'd1) * ((os16_q && clk16_q) ? OS_DIV : 32'd1);
  assign tx_start = ((tx_w >> 1) >= HALF) ? 32'd0 : HALF - (tx_w >> 1);
  assign tx_end   = tx_start + tx_w;
  assign tx_pulse = !txd_q && (32'(phase) >= tx_start) && (32'(phase) < tx_end);
  assign ir_tx    = sw_rst ? 1'b0 : (en_q ? tx_pulse : uart_txd);

  // receive: polarity, glitch filter, bit-long stretch
  logic            rx_q, trig, rx_low;
  logic [HC_W-1:0] hi_cnt, thr;
  logic [TM_W-1:0] timer, load_v;

  assign thr    = (filt_q && rx_len_q != '0) ? {rx_len_q, 1'b0} : HC_W'(1);
  assign trig   = rx_q && (hi_cnt == thr - 1'b1);
  assign load_v = (32'(thr) >= 32'(BIT_CYC)) ? '0 : TM_W'(32'(BIT_CYC) - 32'(thr));
  assign rx_low = trig || (timer != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q <= 1'b0; hi_cnt <= '0; timer <= '0;
    end else if (sw_rst) begin
      rx_q <= 1'b0; hi_cnt <= '0; timer <= '0;
    end else begin
      rx_q   <= ir_rx ^ inv_q;
      hi_cnt <= !rx_q ? '0 : (hi_cnt == HC_MAX) ? HC_MAX : hi_cnt + 1'b1;
      if (trig)              timer <= load_v;
      else if (timer != '0)  timer <= timer - 1'b1;
    end

  assign uart_rxd = sw_rst ? 1'b1 : (en_q ? !rx_low : ir_rx);

  // R2
  tx_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (en_q && ir_tx) |-> !txd_q);
  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase) < 32'(BIT_CYC));
  // R8
  rx_lowstart_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    $rose(rx_low) |-> rx_q);
  // R8
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(timer) < 32'(BIT_CYC));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst |=> ($stable(tx_len_q) && $stable(rx_len_q) && $stable(en_q)));
  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (phase == '0 && hi_cnt == '0 && timer == '0));
endmodule

// File: tb/irda_codec_tb_top.sv
module irda_codec_tb_top;
  localparam int BC = 32;
  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b1;
  logic cfg_en = 1'b0, cfg_os16 = 1'b0, cfg_tx_clk16 = 1'b0;
  logic [5:0] cfg_tx_len = '0, cfg_rx_len = '0;
  logic cfg_rx_inv = 1'b0, cfg_rx_filt = 1'b0;
  logic uart_txd = 1'b1, ir_rx = 1'b0;
  logic ir_tx, uart_rxd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irda_codec #(.BIT_CYC(BC), .LEN_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_en(cfg_en), .cfg_os16(cfg_os16),
    .cfg_tx_clk16(cfg_tx_clk16), .cfg_tx_len(cfg_tx_len), .cfg_rx_inv(cfg_rx_inv),
    .cfg_rx_filt(cfg_rx_filt), .cfg_rx_len(cfg_rx_len), .uart_txd(uart_txd),
    .ir_tx(ir_tx), .ir_rx(ir_rx), .uart_rxd(uart_rxd));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(bit en, bit os, bit c16, int tl, bit inv, bit filt, int fl);
    @(negedge clk);
    sw_rst = 1'b1; cfg_en = en; cfg_os16 = os; cfg_tx_clk16 = c16;
    cfg_tx_len = 6'(tl); cfg_rx_inv = inv; cfg_rx_filt = filt; cfg_rx_len = 6'(fl);
    uart_txd = 1'b1; ir_rx = inv;
    repeat (2) @(negedge clk);
    sw_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic tx_bit(string req, bit b, int exp_first, int exp_cnt);
    int first = 0, cnt = 0;
    uart_txd = b;
    for (int i = 1; i <= BC; i++) begin
      @(negedge clk);
      if (ir_tx) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    uart_txd = 1'b1;
    repeat (BC + 2) @(negedge clk);
    check({req, " pulse count"}, cnt, exp_cnt);
    check({req, " pulse start"}, first, exp_first);
  endtask

  task automatic rx_pulse(string req, int p, int exp_cnt, int exp_last);
    int cnt = 0, last = 0;
    ir_rx = !cfg_rx_inv;
    for (int j = 1; j <= 48; j++) begin
      @(negedge clk);
      if (j == p + 1) ir_rx = cfg_rx_inv;
      if (!uart_rxd) begin
        cnt++;
        last = j;
      end
      if (j == p) ir_rx = cfg_rx_inv;
    end
    check({req, " low cycles"}, cnt, exp_cnt);
    check({req, " low end"}, last, exp_last);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R10 reset ir_tx", int'(ir_tx), 0);
    check("R10 reset uart_rxd", int'(uart_rxd), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_bypass;
    configure(0, 0, 0, 3, 0, 0, 0);
    uart_txd = 1'b0; ir_rx = 1'b0; #1;
    check("R1 bypass tx low", int'(ir_tx), 0);
    check("R1 bypass rx low", int'(uart_rxd), 0);
    uart_txd = 1'b1; ir_rx = 1'b1; #1;
    check("R1 bypass tx high", int'(ir_tx), 1);
    check("R1 bypass rx high", int'(uart_rxd), 1);
  endtask

  task automatic t_tx;
    configure(1, 0, 0, 3, 0, 0, 0);
    check("R2 idle ir_tx", int'(ir_tx), 0);
    tx_bit("R2 len3 base", 1'b0, 15, 4);
    tx_bit("R2 one bit", 1'b1, 0, 0);
    configure(1, 1, 1, 3, 0, 0, 0);
    tx_bit("R3 len3 os16", 1'b0, 13, 8);
    configure(1, 1, 0, 3, 0, 0, 0);
    tx_bit("R3 os16 without select", 1'b0, 15, 4);
    configure(1, 0, 1, 3, 0, 0, 0);
    tx_bit("R3 select without os16", 1'b0, 15, 4);
    configure(1, 0, 0, 0, 0, 0, 0);
    tx_bit("R2 len0", 1'b0, 17, 1);
    configure(1, 0, 0, 63, 0, 0, 0);
    tx_bit("R4 len63 base", 1'b0, 1, 32);
    configure(1, 1, 1, 63, 0, 0, 0);
    tx_bit("R4 len63 os16", 1'b0, 1, 32);
  endtask

  task automatic t_rx;
    configure(1, 0, 0, 0, 0, 0, 5);
    check("R5 idle uart_rxd", int'(uart_rxd), 1);
    rx_pulse("R7 filter off 1-cycle", 1, 32, 32);
    configure(1, 0, 0, 0, 0, 1, 2);
    rx_pulse("R6 below threshold", 3, 0, 0);
    rx_pulse("R8 at threshold", 4, 29, 32);
    configure(1, 0, 0, 0, 1, 1, 3);
    rx_pulse("R5 inverted below", 5, 0, 0);
    rx_pulse("R5 inverted at threshold", 6, 27, 32);
    configure(1, 0, 0, 0, 0, 1, 0);
    rx_pulse("R6 filter len0", 1, 32, 32);
  endtask

  task automatic t_cfg_lock;
    configure(1, 0, 0, 3, 0, 1, 2);
    cfg_tx_len = 6'd63; cfg_en = 1'b0; cfg_os16 = 1'b1; cfg_tx_clk16 = 1'b1;
    cfg_rx_filt = 1'b0;
    tx_bit("R9 tx config ignored", 1'b0, 15, 4);
    rx_pulse("R9 rx config ignored", 3, 0, 0);
  endtask

  task automatic t_swrst;
    configure(1, 0, 0, 63, 0, 0, 0);
    uart_txd = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 pulse before soft reset", int'(ir_tx), 1);
    sw_rst = 1'b1; ir_rx = 1'b1; #1;
    check("R10 soft reset ir_tx", int'(ir_tx), 0);
    check("R10 soft reset uart_rxd", int'(uart_rxd), 1);
    repeat (3) @(negedge clk);
    check("R10 held ir_tx", int'(ir_tx), 0);
    check("R10 held uart_rxd", int'(uart_rxd), 1);
    uart_txd = 1'b1; ir_rx = 1'b0;
    sw_rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 after release uart_rxd", int'(uart_rxd), 1);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_tx();
    t_rx();
    t_cfg_lock();
    t_swrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule